// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Register Front End

This block is the register face of a two-channel serial controller. A CPU reaches it through a simple synchronous bus with separate read and write strobes, an address, and 8-bit data in each direction. Read data comes back one cycle after the read strobe. Each channel has a receive source and a transmit sink, both joined by a valid/ready handshake. Each channel also has a mode byte, a command byte and a read-only status byte built from its handshake and buffer-state inputs.

Both channels share one interrupt status byte and one interrupt mask byte. Channel A owns the low nibble and channel B the high nibble. Each byte can be reached whole or through per-channel nibble windows. Receive-ready bits are raised by arriving data. Transmit-ready bits are raised by a periodic tick. Both kinds are cleared as a side effect of data-register traffic. One registered interrupt line reports whether any enabled status bit is set. The serializers, baud timing and FIFOs sit outside the block.

Top module: `duart_irq_regs`

## Requirements
- R1: After reset the mask, status, mode and command registers are all zero, the interrupt output is low and read data is zero.
- R2: The mode byte (channel base +0x00) and the command byte (base +0x50) read back what was written, with channel A based at 0x100 and channel B at 0x200. Read data appears on the cycle after the read strobe. Any unmapped offset reads as zero.
- R3: The mask byte is read and written whole at 0x3A0. A write to 0x330 replaces only mask bits 3:0. A write to 0x350 loads data bits 3:0 into mask bits 7:4. Reads at 0x330 and 0x350 return the low and high nibble in bits 3:0.
- R4: The status byte reads whole at 0x390, its low nibble at 0x320 and its high nibble (moved into bits 3:0) at 0x340. Bit 0 and bit 1 are channel A transmit-ready and receive-ready. Bit 4 and bit 5 are the same for channel B.
- R5: The channel status byte at base +0x20 has bit0 = receive data available, bit1 = receive buffer full, bit2 = transmitter ready, bit3 = transmitter empty, and bits 7:4 zero.
- R6: While a channel's receive source is valid, its receive-ready status bit is set, but only when that channel's receive mask bit is set.
- R7: A read of a channel's received-data register (base +0x60) with data available returns the byte, pops the source for one cycle and clears that channel's receive-ready status bit. With no data available the read returns zero and does not pop.
- R8: A write to a channel's transmit-data register (base +0x70) clears that channel's transmit-ready status bit. If the sink is ready, the byte is presented to it for one cycle. If the sink is not ready, the byte is dropped and command bit 7 is set, and it stays set until the command byte is rewritten.
- R9: On every second tick pulse, if either transmit mask bit (bit 0 or bit 4) is set, both transmit-ready status bits are set. The first pulse of each pair sets nothing.
- R10: The interrupt output is a register that is high when status AND mask is nonzero, and it follows a change in status or mask one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| rx_valid | input | 2 | Receive byte available, per channel |
| rx_data | input | 16 | Receive bytes, channel A in 7:0 |
| rx_full | input | 2 | Receive buffer full, per channel |
| rx_ready | output | 2 | Receive pop, per channel |
| tx_valid | output | 2 | Transmit byte valid, per channel |
| tx_data | output | 16 | Transmit bytes, channel A in 7:0 |
| tx_ready | input | 2 | Sink can take a byte, per channel |
| tx_empty | input | 2 | Transmitter idle, per channel |
| tick | input | 1 | Periodic tick pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a status byte that already has bits set when the mask changes. Three things have to be staged for it: a receive source held valid while its mask bit is clear, tick pulses counted in pairs, and a status bit left set after the mask that raised it has been switched to another channel. The stimulus holds receive valid with the mask off and checks that no status bit appears. It then enables the mask and times the interrupt edge. After a pop it checks that the interrupt stays high for exactly one more cycle. It sends tick pulses with and without transmit mask bits, and ends by retargeting the mask to an unset bit so the interrupt must drop while status stays nonzero.

// File: rtl/duart_irq_pkg.sv
package duart_irq_pkg;

  localparam int unsigned NCH    = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  // per-channel register offsets, added to the channel base
  localparam logic [11:0] OFS_MODE = 12'h000;
  localparam logic [11:0] OFS_STAT = 12'h020;
  localparam logic [11:0] OFS_CMD  = 12'h050;
  localparam logic [11:0] OFS_RXD  = 12'h060;
  localparam logic [11:0] OFS_TXD  = 12'h070;

  // shared interrupt registers
  localparam logic [11:0] ADR_ISR_ALL = 12'h390;
  localparam logic [11:0] ADR_ISR_LO  = 12'h320;
  localparam logic [11:0] ADR_ISR_HI  = 12'h340;
  localparam logic [11:0] ADR_IMR_ALL = 12'h3A0;
  localparam logic [11:0] ADR_IMR_LO  = 12'h330;
  localparam logic [11:0] ADR_IMR_HI  = 12'h350;

  // bit positions inside a channel nibble of the shared bytes
  localparam int unsigned BIT_TX = 0;
  localparam int unsigned BIT_RX = 1;

  // sticky drop flag in the command byte
  localparam int unsigned CMD_OVR_BIT = 7;

  function automatic logic [11:0] chan_base(input int unsigned ch);
    return 12'(12'h100 * (ch + 1));
  endfunction

endpackage

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [11:0] BASE   = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_full,
  input  logic              tx_ready,
  input  logic              tx_empty,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_wr,
  output logic [BYTE_W-1:0] rd_val
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE + OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(BASE + OFS_CMD);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(BASE + OFS_RXD);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(BASE + OFS_TXD);

  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic              mode_en, cmd_en, drop;
  logic              hit_mode, hit_stat, hit_cmd, hit_rxd, hit_txd;

  assign hit_mode = (addr == A_MODE);
  assign hit_stat = (addr == A_STAT);
  assign hit_cmd  = (addr == A_CMD);
  assign hit_rxd  = (addr == A_RXD);
  assign hit_txd  = (addr == A_TXD);

  // data path handshakes
  assign tx_wr    = wr & hit_txd;
  assign tx_valid = tx_wr & tx_ready;
  assign tx_data  = wdata;
  assign drop     = tx_wr & ~tx_ready;
  assign rx_ready = rd & hit_rxd & rx_valid;

  // next state
  always_comb begin
    mode_en = wr & hit_mode;
    mode_d  = wdata;
    cmd_en  = (wr & hit_cmd) | drop;
    cmd_d   = cmd_q;
    if (wr & hit_cmd) begin
      cmd_d = wdata;
    end else if (drop) begin
      cmd_d[CMD_OVR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  // read value, zero when this channel is not addressed
  always_comb begin
    rd_val = '0;
    if (hit_mode) rd_val = mode_q;
    if (hit_cmd)  rd_val = cmd_q;
    if (hit_stat) rd_val = {{(BYTE_W-4){1'b0}}, tx_empty, tx_ready, rx_full, rx_valid};
    if (hit_rxd)  rd_val = rx_valid ? rx_data : '0;
  end

endmodule

// File: rtl/duart_irq_core.sv
module duart_irq_core
  import duart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH-1:0]    rx_pop,
  input  logic [NCH-1:0]    tx_wr,
  output logic [BYTE_W-1:0] isr,
  output logic [BYTE_W-1:0] imr,
  output logic [BYTE_W-1:0] rd_val,
  output logic              irq
);

  localparam int unsigned CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [BYTE_W-1:0] isr_q, isr_d, imr_q, imr_d, set_v, clr_v, tx_bits;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              imr_en, fire, irq_q, irq_d, tx_mask_any;

  // tick divider
  always_comb begin
    fire  = 1'b0;
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  // mask register with nibble windows
  always_comb begin
    imr_en = 1'b0;
    imr_d  = imr_q;
    if (wr) begin
      if (addr == ADDR_W'(ADR_IMR_ALL)) begin
        imr_en = 1'b1;
        imr_d  = wdata;
      end else if (addr == ADDR_W'(ADR_IMR_LO)) begin
        imr_en = 1'b1;
        imr_d  = {imr_q[BYTE_W-1:NIB_W], wdata[NIB_W-1:0]};
      end else if (addr == ADDR_W'(ADR_IMR_HI)) begin
        imr_en = 1'b1;
        imr_d  = {wdata[NIB_W-1:0], imr_q[NIB_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;
    end else if (imr_en) begin
      imr_q <= imr_d;
    end
  end

  // status set/clear: clear wins over set in the same cycle
  always_comb begin
    set_v   = '0;
    clr_v   = '0;
    tx_bits = '0;
    for (int c = 0; c < NCH; c++) begin
      tx_bits[c*NIB_W + BIT_TX] = 1'b1;
      if (rx_valid[c] && imr_q[c*NIB_W + BIT_RX] && !rx_pop[c]) set_v[c*NIB_W + BIT_RX] = 1'b1;
      if (rx_pop[c]) clr_v[c*NIB_W + BIT_RX] = 1'b1;
      if (tx_wr[c])  clr_v[c*NIB_W + BIT_TX] = 1'b1;
    end
    tx_mask_any = |(imr_q & tx_bits);
    if (fire && tx_mask_any) set_v = set_v | tx_bits;
    isr_d = (isr_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      isr_q <= isr_d;
    end
  end

  assign irq_d = |(isr_q & imr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(ADR_ISR_ALL)) rd_val = isr_q;
    if (addr == ADDR_W'(ADR_ISR_LO))  rd_val = {{NIB_W{1'b0}}, isr_q[NIB_W-1:0]};
    if (addr == ADDR_W'(ADR_ISR_HI))  rd_val = {{NIB_W{1'b0}}, isr_q[BYTE_W-1:NIB_W]};
    if (addr == ADDR_W'(ADR_IMR_ALL)) rd_val = imr_q;
    if (addr == ADDR_W'(ADR_IMR_LO))  rd_val = {{NIB_W{1'b0}}, imr_q[NIB_W-1:0]};
    if (addr == ADDR_W'(ADR_IMR_HI))  rd_val = {{NIB_W{1'b0}}, imr_q[BYTE_W-1:NIB_W]};
  end

  assign isr = isr_q;
  assign imr = imr_q;
  assign irq = irq_q;

endmodule

// File: rtl/duart_irq_regs.sv
module duart_irq_regs
  import duart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [1:0]            rx_valid,
  input  logic [15:0]           rx_data,
  input  logic [1:0]            rx_full,
  output logic [1:0]            rx_ready,
  output logic [1:0]            tx_valid,
  output logic [15:0]           tx_data,
  input  logic [1:0]            tx_ready,
  input  logic [1:0]            tx_empty,
  input  logic                  tick,
  output logic                  irq
);

  logic [BYTE_W-1:0] ch_rdv [NCH];
  logic [NCH-1:0]    tx_wr;
  logic [BYTE_W-1:0] core_rdv, isr, imr, rd_mux, rdata_q, rdata_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duart_chan_regs #(
      .ADDR_W (ADDR_W),
      .BASE   (chan_base(c))
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid[c]),
      .rx_data  (rx_data[c*BYTE_W +: BYTE_W]),
      .rx_full  (rx_full[c]),
      .tx_ready (tx_ready[c]),
      .tx_empty (tx_empty[c]),
      .rx_ready (rx_ready[c]),
      .tx_valid (tx_valid[c]),
      .tx_data  (tx_data[c*BYTE_W +: BYTE_W]),
      .tx_wr    (tx_wr[c]),
      .rd_val   (ch_rdv[c])
    );
  end

  duart_irq_core #(
    .ADDR_W   (ADDR_W),
    .TICK_DIV (TICK_DIV)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .tick     (tick),
    .rx_valid (rx_valid),
    .rx_pop   (rx_ready),
    .tx_wr    (tx_wr),
    .isr      (isr),
    .imr      (imr),
    .rd_val   (core_rdv),
    .irq      (irq)
  );

  // address windows are disjoint, so an OR merges the read sources
  always_comb begin
    rd_mux = core_rdv;
    for (int c = 0; c < NCH; c++) rd_mux = rd_mux | ch_rdv[c];
    rdata_d = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/duart_irq_chk.sv
module duart_irq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        isr,
  input logic [7:0]        imr,
  input logic [1:0]        rx_valid,
  input logic [1:0]        rx_ready,
  input logic [1:0]        tx_valid,
  input logic [1:0]        tx_ready,
  input logic              irq
);

  assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & imr) != 8'h00) |=> irq);

  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & imr) == 8'h00) |=> !irq);

  assert_pop_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready & ~rx_valid) == 2'b00);

  assert_pop_clears_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready[0] |=> !isr[1]);

  assert_pop_clears_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready[1] |=> !isr[5]);

  assert_push_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid & ~tx_ready) == 2'b00);

  assert_masked_rx_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!imr[1] && !isr[1]) |=> !isr[1]);

  assert_masked_rx_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!imr[5] && !isr[5]) |=> !isr[5]);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(16'h0010)) |=> (bus_rdata == 8'h00));

endmodule

bind duart_irq_regs duart_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .isr       (isr),
  .imr       (imr),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .irq       (irq)
);

// File: tb/tb_duart_irq_regs.sv
`timescale 1ns/1ps
module tb_duart_irq_regs;

  logic        clk, rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  rx_valid, rx_full, rx_ready, tx_valid, tx_ready, tx_empty;
  logic [15:0] rx_data, tx_data;
  logic        tick, irq;

  duart_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_full(rx_full), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .tick(tick), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int pops0 = 0, pops1 = 0, push0 = 0, push1 = 0;
  logic [7:0] last_tx0 = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;
  bit         done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitors
  always @(posedge clk) begin
    rd_pend <= bus_rd;
    if (rx_ready[0]) pops0++;
    if (rx_ready[1]) pops1++;
    if (tx_valid[0]) begin push0++; last_tx0 = tx_data[7:0]; end
    if (tx_valid[1]) push1++;
  end

  // scoreboard: one expected byte per read, compared one cycle later
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL scoreboard: actual=%02h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // received-data read; the source drops valid after the pop edge
  task automatic rd_rx(input int ch, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = (ch == 0) ? 16'h0160 : 16'h0260; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0; rx_valid[ch] = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    rx_valid = 2'b00; rx_data = 16'h7741; rx_full = 2'b10;
    tx_ready = 2'b01; tx_empty = 2'b01; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rd(16'h03A0, 8'h00, "R1 mask");
    rd(16'h0390, 8'h00, "R1 status");
    rd(16'h0100, 8'h00, "R1 mode A");
    rd(16'h0250, 8'h00, "R1 cmd B");

    // R2 mode/cmd and unmapped
    wr(16'h0100, 8'h5A);
    wr(16'h0250, 8'h3C);
    rd(16'h0100, 8'h5A, "R2 mode A");
    rd(16'h0250, 8'h3C, "R2 cmd B");
    rd(16'h0200, 8'h00, "R2 mode B untouched");
    rd(16'h0010, 8'h00, "R2 unmapped 0x010");
    rd(16'h03B0, 8'h00, "R2 unmapped 0x3B0");

    // R3 mask views
    wr(16'h03A0, 8'hF0);
    wr(16'h0330, 8'hA3);
    rd(16'h03A0, 8'hF3, "R3 low nibble write");
    wr(16'h0350, 8'h52);
    rd(16'h03A0, 8'h23, "R3 high nibble write");
    rd(16'h0330, 8'h03, "R3 low view");
    rd(16'h0350, 8'h02, "R3 high view");

    // R5 status bytes; R6 masked arrival sets nothing
    wr(16'h03A0, 8'h01);
    rx_valid[0] = 1'b1;
    rd(16'h0120, 8'h0D, "R5 status A");
    rd(16'h0220, 8'h02, "R5 status B");
    rd(16'h0390, 8'h00, "R6 masked rx");
    check("R6 irq masked", {7'b0, irq}, 8'h00);

    // R6 enabled arrival, R10 timing
    wr(16'h03A0, 8'h02);
    @(negedge clk);
    check("R10 irq lag", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq set", {7'b0, irq}, 8'h01);
    rd(16'h0390, 8'h02, "R6 rx A set");

    // R7 pop clears, irq one cycle later
    rd_rx(0, 8'h41, "R7 rx A data");
    check("R10 irq holds one cycle", {7'b0, irq}, 8'h01);
    @(negedge clk);
    check("R10 irq clears", {7'b0, irq}, 8'h00);
    check("R7 pop count A", 8'(pops0), 8'd1);
    rd(16'h0390, 8'h00, "R7 rx A cleared");
    rd(16'h0160, 8'h00, "R7 empty read");
    check("R7 empty no pop", 8'(pops0), 8'd1);

    // R4 high nibble views
    rx_valid[1] = 1'b1;
    wr(16'h03A0, 8'h20);
    rd(16'h0390, 8'h20, "R4 whole");
    rd(16'h0340, 8'h02, "R4 high view");
    rd(16'h0320, 8'h00, "R4 low view");
    rd_rx(1, 8'h77, "R7 rx B data");
    check("R7 pop count B", 8'(pops1), 8'd1);

    // R9 ticks
    wr(16'h03A0, 8'h00);
    pulse_tick(); pulse_tick();
    rd(16'h0390, 8'h00, "R9 no tx mask");
    wr(16'h03A0, 8'h10);
    pulse_tick();
    rd(16'h0390, 8'h00, "R9 first pulse");
    pulse_tick();
    rd(16'h0390, 8'h11, "R9 second pulse");

    // R8 transmit
    wr(16'h0170, 8'h55);
    check("R8 push A", 8'(push0), 8'd1);
    check("R8 data A", last_tx0, 8'h55);
    rd(16'h0390, 8'h10, "R8 tx A cleared");
    check("R10 irq tx B", {7'b0, irq}, 8'h01);
    wr(16'h0270, 8'h99);
    check("R8 drop B", 8'(push1), 8'd0);
    rd(16'h0390, 8'h00, "R8 tx B cleared");
    rd(16'h0250, 8'hBC, "R8 overrun sticky");
    wr(16'h0250, 8'h01);
    rd(16'h0250, 8'h01, "R8 overrun cleared by write");

    // R10 mask retarget drops irq while status stays set
    pulse_tick(); pulse_tick();
    rd(16'h0390, 8'h11, "R9 both tx set");
    check("R10 irq on", {7'b0, irq}, 8'h01);
    wr(16'h03A0, 8'h20);
    @(negedge clk);
    check("R10 irq off", {7'b0, irq}, 8'h00);
    rd(16'h0390, 8'h11, "R10 status kept");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule